// File: doc/BRIEF.md
# Dual-Port Doorbell Queue Register File

This block links a producer agent and a consumer agent through a small register file, with one AXI4-Lite subordinate port for each agent. The producer owns the submission queue and the consumer owns the completion queue. Each queue has a tail-pointer doorbell, an interrupt trigger and status word, a control word and a 64-bit queue memory address split into two halves. Each port writes its own queue in the low window (offsets 0x000 to 0x010). It sees the peer queue read-only in the high window (offsets 0x100 to 0x110).

Each queue drives one interrupt line. The control word picks what raises the line. In doorbell mode, any write to the tail pointer raises it, and the peer clears it by reading the mirrored tail pointer. In trigger mode, writing a one to the trigger bit raises it, and the peer clears it by reading the mirrored status word. Setting the soft-reset bit in either control word returns both queues to zero. Queue entry storage and head pointers live outside the block.

Top module: `dbq_regfile`

## Requirements
- R1: After rst_ni is released, every readable offset on both ports returns 0 and both interrupt outputs are low.
- R2: In the own window, the tail pointer (0x000), address low (0x008) and address high (0x010) are read/write. A write updates byte lane k only where write-strobe bit k is set.
- R3: The high window returns the peer queue's registers: tail at 0x100, status at 0x104 (bit 0), address low at 0x108, control at 0x10C and address high at 0x110. Writes there change nothing.
- R4: The control word at 0x00C holds the enable in bit 0 and the mode in bit 1 (0 = doorbell, 1 = trigger), and lane 0 writes it. A read of bit 31 returns 0. At 0x004, bit 0 (the trigger) always reads 0 and bit 1 shows the queue's interrupt output.
- R5: In doorbell mode with enable set, a write to the own tail raises the queue interrupt. Only a peer read of 0x100 clears it. A peer read of 0x104 leaves it set.
- R6: In trigger mode with enable set, a write to 0x004 with strobe bit 0 set and data bit 0 set raises the queue interrupt. A tail write does not raise it. Only a peer read of 0x104 clears it. A peer read of 0x100 leaves it set.
- R7: With enable clear, no event sets the pending interrupt. The interrupt output and its status bit show pending AND enable, so clearing enable masks a pending interrupt and setting enable again shows it.
- R8: A write to 0x00C with strobe bit 3 set and data bit 31 set, from either port, clears all registers of both queues and both interrupts.
- R9: A write to a read-only or unmapped offset completes with response OKAY (0) and changes nothing. A read of an unmapped offset returns 0 with response OKAY.
- R10: Write address and write data may arrive in either order. The write response comes only after both are captured, and bresp is always OKAY. Each port takes one write and one read at a time.
- R11: bvalid and rvalid stay high, with rdata stable, until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prd_awaddr_i | input | 12 | Producer write address |
| prd_awvalid_i | input | 1 | Producer write address valid |
| prd_awready_o | output | 1 | Producer write address ready |
| prd_wdata_i | input | 32 | Producer write data |
| prd_wstrb_i | input | 4 | Producer write strobes |
| prd_wvalid_i | input | 1 | Producer write data valid |
| prd_wready_o | output | 1 | Producer write data ready |
| prd_bresp_o | output | 2 | Producer write response |
| prd_bvalid_o | output | 1 | Producer write response valid |
| prd_bready_i | input | 1 | Producer write response ready |
| prd_araddr_i | input | 12 | Producer read address |
| prd_arvalid_i | input | 1 | Producer read address valid |
| prd_arready_o | output | 1 | Producer read address ready |
| prd_rdata_o | output | 32 | Producer read data |
| prd_rresp_o | output | 2 | Producer read response |
| prd_rvalid_o | output | 1 | Producer read valid |
| prd_rready_i | input | 1 | Producer read ready |
| con_awaddr_i | input | 12 | Consumer write address |
| con_awvalid_i | input | 1 | Consumer write address valid |
| con_awready_o | output | 1 | Consumer write address ready |
| con_wdata_i | input | 32 | Consumer write data |
| con_wstrb_i | input | 4 | Consumer write strobes |
| con_wvalid_i | input | 1 | Consumer write data valid |
| con_wready_o | output | 1 | Consumer write data ready |
| con_bresp_o | output | 2 | Consumer write response |
| con_bvalid_o | output | 1 | Consumer write response valid |
| con_bready_i | input | 1 | Consumer write response ready |
| con_araddr_i | input | 12 | Consumer read address |
| con_arvalid_i | input | 1 | Consumer read address valid |
| con_arready_o | output | 1 | Consumer read address ready |
| con_rdata_o | output | 32 | Consumer read data |
| con_rresp_o | output | 2 | Consumer read response |
| con_rvalid_o | output | 1 | Consumer read valid |
| con_rready_i | input | 1 | Consumer read ready |
| irq_sq_o | output | 1 | Submission queue interrupt |
| irq_cq_o | output | 1 | Completion queue interrupt |

## Verification
The assertions rely on the masters keeping to AXI4-Lite handshake rules. They also rely on the interrupt lines changing only through register accesses. That lets them tie every rise of an interrupt to a write response on the owning port, and every fall to a read handshake on the peer or a write response on either port. The bench drives each valid from the falling edge and holds it until ready has been sampled high. It issues one transaction at a time per port and varies the order of address and data and the delay before the response is accepted. Random data and strobes are masked so that the soft-reset bit is set only on rare, known operations, and the bench model follows every one of them.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
  localparam int WIDX_W = 10;
  // word indices (byte offset >> 2); peer mirror sits at own index + 0x40
  localparam logic [WIDX_W-1:0] W_TAIL = 10'h000;
  localparam logic [WIDX_W-1:0] W_IRQ  = 10'h001;
  localparam logic [WIDX_W-1:0] W_ALO  = 10'h002;
  localparam logic [WIDX_W-1:0] W_CTRL = 10'h003;
  localparam logic [WIDX_W-1:0] W_AHI  = 10'h004;
  localparam logic [WIDX_W-1:0] W_MIR  = 10'h040;
  localparam int SRST_BIT = 31;

  function automatic logic [31:0] apply_strb(logic [31:0] old_v, logic [31:0] new_v,
                                             logic [3:0] strb);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[b*8 +: 8] = strb[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/dbq_axil_port.sv
module dbq_axil_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [STRB_W-1:0] wstrb_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] rdata_i
);
  logic aw_h, w_h;

  assign awready_o = !aw_h && !bvalid_o;
  assign wready_o  = !w_h && !bvalid_o;
  assign we_o      = aw_h && w_h;
  assign bresp_o   = 2'b00;
  assign rresp_o   = 2'b00;
  assign arready_o = !rvalid_o;
  assign re_o      = arvalid_i && arready_o;
  assign raddr_o   = araddr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_h <= 1'b0; w_h <= 1'b0; bvalid_o <= 1'b0;
      waddr_o <= '0; wdata_o <= '0; wstrb_o <= '0;
    end else begin
      if (awvalid_i && awready_o) begin aw_h <= 1'b1; waddr_o <= awaddr_i; end
      if (wvalid_i && wready_o) begin w_h <= 1'b1; wdata_o <= wdata_i; wstrb_o <= wstrb_i; end
      if (we_o) begin
        aw_h <= 1'b0; w_h <= 1'b0; bvalid_o <= 1'b1;
      end else if (bvalid_o && bready_i) begin
        bvalid_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0; rdata_o <= '0;
    end else if (re_o) begin
      rvalid_o <= 1'b1; rdata_o <= rdata_i;
    end else if (rvalid_o && rready_i) begin
      rvalid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dbq_queue_regs.sv
module dbq_queue_regs
  import dbq_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              peer_rd_tail_i,
  input  logic              peer_rd_stat_i,
  output logic [DATA_W-1:0] tail_o,
  output logic [DATA_W-1:0] alo_o,
  output logic [DATA_W-1:0] ahi_o,
  output logic              ien_o,
  output logic              ity_o,
  output logic              irq_o
);
  logic pend, set_ev, clr_ev;

  assign set_ev = we_i && ien_o &&
                  ((!ity_o && widx_i == W_TAIL) ||
                   (ity_o && widx_i == W_IRQ && wstrb_i[0] && wdata_i[0]));
  assign clr_ev = (!ity_o && peer_rd_tail_i) || (ity_o && peer_rd_stat_i);
  assign irq_o  = pend && ien_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_o <= '0; alo_o <= '0; ahi_o <= '0; ien_o <= 1'b0; ity_o <= 1'b0; pend <= 1'b0;
    end else if (clr_i) begin
      tail_o <= '0; alo_o <= '0; ahi_o <= '0; ien_o <= 1'b0; ity_o <= 1'b0; pend <= 1'b0;
    end else begin
      if (we_i) begin
        unique case (widx_i)
          W_TAIL:  tail_o <= apply_strb(tail_o, wdata_i, wstrb_i);
          W_ALO:   alo_o  <= apply_strb(alo_o, wdata_i, wstrb_i);
          W_AHI:   ahi_o  <= apply_strb(ahi_o, wdata_i, wstrb_i);
          W_CTRL:  if (wstrb_i[0]) begin ien_o <= wdata_i[0]; ity_o <= wdata_i[1]; end
          default: ;
        endcase
      end
      // a new event wins over a same-cycle clear
      if (set_ev)      pend <= 1'b1;
      else if (clr_ev) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dbq_regfile.sv
module dbq_regfile
  import dbq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8,
  localparam int NPORT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] prd_awaddr_i,
  input  logic              prd_awvalid_i,
  output logic              prd_awready_o,
  input  logic [DATA_W-1:0] prd_wdata_i,
  input  logic [STRB_W-1:0] prd_wstrb_i,
  input  logic              prd_wvalid_i,
  output logic              prd_wready_o,
  output logic [1:0]        prd_bresp_o,
  output logic              prd_bvalid_o,
  input  logic              prd_bready_i,
  input  logic [ADDR_W-1:0] prd_araddr_i,
  input  logic              prd_arvalid_i,
  output logic              prd_arready_o,
  output logic [DATA_W-1:0] prd_rdata_o,
  output logic [1:0]        prd_rresp_o,
  output logic              prd_rvalid_o,
  input  logic              prd_rready_i,
  input  logic [ADDR_W-1:0] con_awaddr_i,
  input  logic              con_awvalid_i,
  output logic              con_awready_o,
  input  logic [DATA_W-1:0] con_wdata_i,
  input  logic [STRB_W-1:0] con_wstrb_i,
  input  logic              con_wvalid_i,
  output logic              con_wready_o,
  output logic [1:0]        con_bresp_o,
  output logic              con_bvalid_o,
  input  logic              con_bready_i,
  input  logic [ADDR_W-1:0] con_araddr_i,
  input  logic              con_arvalid_i,
  output logic              con_arready_o,
  output logic [DATA_W-1:0] con_rdata_o,
  output logic [1:0]        con_rresp_o,
  output logic              con_rvalid_o,
  input  logic              con_rready_i,
  output logic              irq_sq_o,
  output logic              irq_cq_o
);
  logic              we    [NPORT];
  logic [ADDR_W-1:0] waddr [NPORT];
  logic [DATA_W-1:0] wdata [NPORT];
  logic [STRB_W-1:0] wstrb [NPORT];
  logic              re    [NPORT];
  logic [ADDR_W-1:0] raddr [NPORT];
  logic [DATA_W-1:0] rmux  [NPORT];
  logic [DATA_W-1:0] tail  [NPORT];
  logic [DATA_W-1:0] alo   [NPORT];
  logic [DATA_W-1:0] ahi   [NPORT];
  logic              ien   [NPORT];
  logic              ity   [NPORT];
  logic              irqv  [NPORT];
  logic [NPORT-1:0]  srst_req;
  logic              soft_rst;

  dbq_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_prd (
    .clk_i, .rst_ni,
    .awaddr_i(prd_awaddr_i), .awvalid_i(prd_awvalid_i), .awready_o(prd_awready_o),
    .wdata_i(prd_wdata_i), .wstrb_i(prd_wstrb_i), .wvalid_i(prd_wvalid_i), .wready_o(prd_wready_o),
    .bresp_o(prd_bresp_o), .bvalid_o(prd_bvalid_o), .bready_i(prd_bready_i),
    .araddr_i(prd_araddr_i), .arvalid_i(prd_arvalid_i), .arready_o(prd_arready_o),
    .rdata_o(prd_rdata_o), .rresp_o(prd_rresp_o), .rvalid_o(prd_rvalid_o), .rready_i(prd_rready_i),
    .we_o(we[0]), .waddr_o(waddr[0]), .wdata_o(wdata[0]), .wstrb_o(wstrb[0]),
    .re_o(re[0]), .raddr_o(raddr[0]), .rdata_i(rmux[0])
  );

  dbq_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_con (
    .clk_i, .rst_ni,
    .awaddr_i(con_awaddr_i), .awvalid_i(con_awvalid_i), .awready_o(con_awready_o),
    .wdata_i(con_wdata_i), .wstrb_i(con_wstrb_i), .wvalid_i(con_wvalid_i), .wready_o(con_wready_o),
    .bresp_o(con_bresp_o), .bvalid_o(con_bvalid_o), .bready_i(con_bready_i),
    .araddr_i(con_araddr_i), .arvalid_i(con_arvalid_i), .arready_o(con_arready_o),
    .rdata_o(con_rdata_o), .rresp_o(con_rresp_o), .rvalid_o(con_rvalid_o), .rready_i(con_rready_i),
    .we_o(we[1]), .waddr_o(waddr[1]), .wdata_o(wdata[1]), .wstrb_o(wstrb[1]),
    .re_o(re[1]), .raddr_o(raddr[1]), .rdata_i(rmux[1])
  );

  assign soft_rst = |srst_req;

  // queue q is owned by port q; its peer is port NPORT-1-q
  for (genvar q = 0; q < NPORT; q++) begin : g_q
    localparam int PEER = NPORT - 1 - q;
    logic [WIDX_W-1:0] widx, ridx;
    assign widx = waddr[q][ADDR_W-1:2];
    assign ridx = raddr[q][ADDR_W-1:2];
    assign srst_req[q] = we[q] && widx == W_CTRL && wstrb[q][3] && wdata[q][SRST_BIT];

    dbq_queue_regs #(.DATA_W(DATA_W)) u_regs (
      .clk_i, .rst_ni, .clr_i(soft_rst),
      .we_i(we[q]), .widx_i(widx), .wdata_i(wdata[q]), .wstrb_i(wstrb[q]),
      .peer_rd_tail_i(re[PEER] && raddr[PEER][ADDR_W-1:2] == (W_MIR | W_TAIL)),
      .peer_rd_stat_i(re[PEER] && raddr[PEER][ADDR_W-1:2] == (W_MIR | W_IRQ)),
      .tail_o(tail[q]), .alo_o(alo[q]), .ahi_o(ahi[q]),
      .ien_o(ien[q]), .ity_o(ity[q]), .irq_o(irqv[q])
    );

    always_comb begin
      rmux[q] = '0;
      unique case (ridx)
        W_TAIL:         rmux[q] = tail[q];
        W_IRQ:          rmux[q][1] = irqv[q];
        W_ALO:          rmux[q] = alo[q];
        W_CTRL:         rmux[q][1:0] = {ity[q], ien[q]};
        W_AHI:          rmux[q] = ahi[q];
        W_MIR | W_TAIL: rmux[q] = tail[PEER];
        W_MIR | W_IRQ:  rmux[q][0] = irqv[PEER];
        W_MIR | W_ALO:  rmux[q] = alo[PEER];
        W_MIR | W_CTRL: rmux[q][1:0] = {ity[PEER], ien[PEER]};
        W_MIR | W_AHI:  rmux[q] = ahi[PEER];
        default:        rmux[q] = '0;
      endcase
    end
  end

  assign irq_sq_o = irqv[0];
  assign irq_cq_o = irqv[1];
endmodule

// File: rtl/dbq_checker.sv
module dbq_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prd_awready_o,
  input logic [1:0]        prd_bresp_o,
  input logic              prd_bvalid_o,
  input logic              prd_bready_i,
  input logic              prd_arvalid_i,
  input logic              prd_arready_o,
  input logic [DATA_W-1:0] prd_rdata_o,
  input logic [1:0]        prd_rresp_o,
  input logic              prd_rvalid_o,
  input logic              prd_rready_i,
  input logic              con_awready_o,
  input logic [1:0]        con_bresp_o,
  input logic              con_bvalid_o,
  input logic              con_bready_i,
  input logic              con_arvalid_i,
  input logic              con_arready_o,
  input logic [DATA_W-1:0] con_rdata_o,
  input logic [1:0]        con_rresp_o,
  input logic              con_rvalid_o,
  input logic              con_rready_i,
  input logic              irq_sq_o,
  input logic              irq_cq_o
);
  p_bresp_okay_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prd_bvalid_o |-> prd_bresp_o == 2'b00) and (con_bvalid_o |-> con_bresp_o == 2'b00));
  p_rresp_okay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prd_rvalid_o |-> prd_rresp_o == 2'b00) and (con_rvalid_o |-> con_rresp_o == 2'b00));
  p_one_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prd_bvalid_o && prd_awready_o) && !(con_bvalid_o && con_awready_o));
  p_prd_bhold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_bvalid_o && !prd_bready_i |=> prd_bvalid_o);
  p_con_bhold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    con_bvalid_o && !con_bready_i |=> con_bvalid_o);
  p_prd_rhold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_rvalid_o && !prd_rready_i |=> prd_rvalid_o && $stable(prd_rdata_o));
  p_con_rhold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    con_rvalid_o && !con_rready_i |=> con_rvalid_o && $stable(con_rdata_o));
  // R5/R6: an interrupt only rises together with a write commit on its owning port
  p_sq_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_sq_o) |-> $rose(prd_bvalid_o));
  p_cq_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_cq_o) |-> $rose(con_bvalid_o));
  // R7/R8: an interrupt only falls after a peer read or a write commit
  p_sq_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_sq_o) |-> $past(con_arvalid_i && con_arready_o) || $rose(prd_bvalid_o) || $rose(con_bvalid_o));
  p_cq_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_cq_o) |-> $past(prd_arvalid_i && prd_arready_o) || $rose(prd_bvalid_o) || $rose(con_bvalid_o));
endmodule

bind dbq_regfile dbq_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni,
  .prd_awready_o, .prd_bresp_o, .prd_bvalid_o, .prd_bready_i, .prd_arvalid_i, .prd_arready_o,
  .prd_rdata_o, .prd_rresp_o, .prd_rvalid_o, .prd_rready_i,
  .con_awready_o, .con_bresp_o, .con_bvalid_o, .con_bready_i, .con_arvalid_i, .con_arready_o,
  .con_rdata_o, .con_rresp_o, .con_rvalid_o, .con_rready_i,
  .irq_sq_o, .irq_cq_o
);

// File: tb/sim_dbq_regfile.sv
`timescale 1ns/1ps
module sim_dbq_regfile;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [11:0] awaddr [2], araddr [2];
  logic [31:0] wdata [2], rdata [2];
  logic [3:0]  wstrb [2];
  logic awvalid [2], wvalid [2], bready [2], arvalid [2], rready [2];
  logic awready [2], wready [2], bvalid [2], arready [2], rvalid [2];
  logic [1:0] bresp [2], rresp [2];
  logic irq_sq, irq_cq;

  dbq_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .prd_awaddr_i(awaddr[0]), .prd_awvalid_i(awvalid[0]), .prd_awready_o(awready[0]),
    .prd_wdata_i(wdata[0]), .prd_wstrb_i(wstrb[0]), .prd_wvalid_i(wvalid[0]), .prd_wready_o(wready[0]),
    .prd_bresp_o(bresp[0]), .prd_bvalid_o(bvalid[0]), .prd_bready_i(bready[0]),
    .prd_araddr_i(araddr[0]), .prd_arvalid_i(arvalid[0]), .prd_arready_o(arready[0]),
    .prd_rdata_o(rdata[0]), .prd_rresp_o(rresp[0]), .prd_rvalid_o(rvalid[0]), .prd_rready_i(rready[0]),
    .con_awaddr_i(awaddr[1]), .con_awvalid_i(awvalid[1]), .con_awready_o(awready[1]),
    .con_wdata_i(wdata[1]), .con_wstrb_i(wstrb[1]), .con_wvalid_i(wvalid[1]), .con_wready_o(wready[1]),
    .con_bresp_o(bresp[1]), .con_bvalid_o(bvalid[1]), .con_bready_i(bready[1]),
    .con_araddr_i(araddr[1]), .con_arvalid_i(arvalid[1]), .con_arready_o(arready[1]),
    .con_rdata_o(rdata[1]), .con_rresp_o(rresp[1]), .con_rvalid_o(rvalid[1]), .con_rready_i(rready[1]),
    .irq_sq_o(irq_sq), .irq_cq_o(irq_cq)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_tail [2], m_lo [2], m_hi [2];
  logic m_en [2], m_ty [2], m_pd [2];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] d, logic [3:0] s);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic void m_clear();
    for (int q = 0; q < 2; q++) begin
      m_tail[q] = 0; m_lo[q] = 0; m_hi[q] = 0; m_en[q] = 0; m_ty[q] = 0; m_pd[q] = 0;
    end
  endfunction

  function automatic logic m_irq(int q);
    return m_pd[q] & m_en[q];
  endfunction

  function automatic logic [31:0] m_rd_val(int p, logic [11:0] a);
    int q = 1 - p;
    case (a[11:2])
      10'h000: return m_tail[p];
      10'h001: return {30'b0, m_irq(p), 1'b0};
      10'h002: return m_lo[p];
      10'h003: return {30'b0, m_ty[p], m_en[p]};
      10'h004: return m_hi[p];
      10'h040: return m_tail[q];
      10'h041: return {31'b0, m_irq(q)};
      10'h042: return m_lo[q];
      10'h043: return {30'b0, m_ty[q], m_en[q]};
      10'h044: return m_hi[q];
      default: return 32'h0;
    endcase
  endfunction

  function automatic void m_wr(int p, logic [11:0] a, logic [31:0] d, logic [3:0] s);
    logic set;
    logic [9:0] w = a[11:2];
    if (w == 10'h003 && s[3] && d[31]) begin m_clear(); return; end
    set = m_en[p] && ((!m_ty[p] && w == 10'h000) || (m_ty[p] && w == 10'h001 && s[0] && d[0]));
    case (w)
      10'h000: m_tail[p] = merge(m_tail[p], d, s);
      10'h002: m_lo[p] = merge(m_lo[p], d, s);
      10'h004: m_hi[p] = merge(m_hi[p], d, s);
      10'h003: if (s[0]) begin m_en[p] = d[0]; m_ty[p] = d[1]; end
      default: ;
    endcase
    if (set) m_pd[p] = 1'b1;
  endfunction

  function automatic void m_rd(int p, logic [11:0] a);
    int q = 1 - p;
    if (!m_ty[q] && a[11:2] == 10'h040) m_pd[q] = 1'b0;
    if (m_ty[q] && a[11:2] == 10'h041) m_pd[q] = 1'b0;
  endfunction

  // ord: 0 together, 1 address first, 2 data first; bdly cycles before bready
  task automatic wr(int p, logic [11:0] a, logic [31:0] d, logic [3:0] s, int ord = 0, int bdly = 0);
    logic ok;
    @(negedge clk);
    awaddr[p] = a; wdata[p] = d; wstrb[p] = s;
    if (ord != 2) awvalid[p] = 1'b1;
    if (ord != 1) wvalid[p] = 1'b1;
    repeat (3) begin
      ok = (awvalid[p] && awready[p]) || (wvalid[p] && wready[p]);
      @(negedge clk);
      if (ok) begin awvalid[p] = 1'b0; wvalid[p] = 1'b0; end
    end
    if (ord != 0) chk("R10 no response before both channels", {31'b0, bvalid[p]}, 32'h0);
    awvalid[p] = (ord == 2); wvalid[p] = (ord == 1);
    while (awvalid[p] || wvalid[p]) begin
      if (awvalid[p] && awready[p]) begin @(negedge clk); awvalid[p] = 1'b0; end
      else if (wvalid[p] && wready[p]) begin @(negedge clk); wvalid[p] = 1'b0; end
      else @(negedge clk);
    end
    while (!bvalid[p]) @(negedge clk);
    repeat (bdly) begin
      @(negedge clk);
      chk("R11 bvalid held without bready", {31'b0, bvalid[p]}, 32'h1);
    end
    chk("R10 bresp OKAY", {30'b0, bresp[p]}, 32'h0);
    bready[p] = 1'b1;
    @(negedge clk);
    bready[p] = 1'b0;
    m_wr(p, a, d, s);
  endtask

  task automatic rd(int p, logic [11:0] a, output logic [31:0] v, input int rdly = 0);
    @(negedge clk);
    araddr[p] = a; arvalid[p] = 1'b1;
    while (!arready[p]) @(negedge clk);
    @(negedge clk);
    arvalid[p] = 1'b0;
    while (!rvalid[p]) @(negedge clk);
    v = rdata[p];
    repeat (rdly) begin
      @(negedge clk);
      chk("R11 rdata held without rready", rdata[p], v);
    end
    chk("R9 rresp OKAY", {30'b0, rresp[p]}, 32'h0);
    rready[p] = 1'b1;
    @(negedge clk);
    rready[p] = 1'b0;
    m_rd(p, a);
  endtask

  task automatic rd_chk(string r, int p, logic [11:0] a);
    logic [31:0] v, e;
    e = m_rd_val(p, a);
    rd(p, a, v);
    chk(r, v, e);
  endtask

  task automatic irq_chk(string r);
    chk({r, " irq_sq"}, {31'b0, irq_sq}, {31'b0, m_irq(0)});
    chk({r, " irq_cq"}, {31'b0, irq_cq}, {31'b0, m_irq(1)});
  endtask

  logic [11:0] offs [12] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h100,
                             12'h104, 12'h108, 12'h10C, 12'h110, 12'h200, 12'h014};

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'hC0FFEE));
    for (int p = 0; p < 2; p++) begin
      awaddr[p] = 0; araddr[p] = 0; wdata[p] = 0; wstrb[p] = 0;
      awvalid[p] = 0; wvalid[p] = 0; bready[p] = 0; arvalid[p] = 0; rready[p] = 0;
    end
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 10; i++) begin
        rd(p, offs[i], v);
        chk("R1 reset value", v, 32'h0);
      end
    irq_chk("R1");

    // R2 full and partial writes
    wr(0, 12'h000, 32'hDEADBEEF, 4'hF);
    rd_chk("R2 tail readback", 0, 12'h000);
    wr(0, 12'h008, 32'h11223344, 4'b0101);
    rd_chk("R2 strobed address low", 0, 12'h008);
    chk("R2 strobed lanes", m_lo[0], 32'h00220044);
    wr(1, 12'h010, 32'hA5A5A5A5, 4'b1000);
    rd_chk("R2 strobed address high", 1, 12'h010);

    // R3 mirror and ignored high-window writes
    rd_chk("R3 peer tail", 1, 12'h100);
    rd_chk("R3 peer address low", 1, 12'h108);
    rd_chk("R3 peer address high", 0, 12'h110);
    wr(1, 12'h100, 32'h12345678, 4'hF);
    rd_chk("R3 write to mirror ignored", 0, 12'h000);
    chk("R3 tail unchanged", m_tail[0], 32'hDEADBEEF);

    // R4 control fields, self-clearing reset bit and trigger bit read as zero
    wr(0, 12'h00C, 32'h0000_0002, 4'h1);
    rd_chk("R4 control readback", 0, 12'h00C);
    rd_chk("R4 control in peer mirror", 1, 12'h10C);
    wr(0, 12'h004, 32'h1, 4'h1);
    rd_chk("R4 trigger bit reads zero", 0, 12'h004);

    // R5 doorbell mode on the submission queue
    wr(0, 12'h00C, 32'h1, 4'h1);
    wr(0, 12'h000, 32'h5, 4'hF, 1);
    chk("R5 doorbell raises irq_sq", {31'b0, irq_sq}, 32'h1);
    rd_chk("R5 own status bit", 0, 12'h004);
    rd_chk("R5 status read does not clear", 1, 12'h104);
    chk("R5 irq_sq still set", {31'b0, irq_sq}, 32'h1);
    rd_chk("R5 peer tail read", 1, 12'h100);
    chk("R5 peer tail read clears", {31'b0, irq_sq}, 32'h0);

    // R6 trigger mode on the completion queue
    wr(1, 12'h00C, 32'h3, 4'h1, 2);
    wr(1, 12'h000, 32'h9, 4'hF);
    chk("R6 tail write no irq in trigger mode", {31'b0, irq_cq}, 32'h0);
    wr(1, 12'h004, 32'h1, 4'h1);
    chk("R6 trigger raises irq_cq", {31'b0, irq_cq}, 32'h1);
    rd_chk("R6 peer tail read", 0, 12'h100);
    chk("R6 tail read does not clear", {31'b0, irq_cq}, 32'h1);
    rd_chk("R6 peer status read", 0, 12'h104);
    chk("R6 status read clears", {31'b0, irq_cq}, 32'h0);

    // R7 enable gating
    wr(0, 12'h00C, 32'h0, 4'h1);
    wr(0, 12'h000, 32'h6, 4'hF);
    chk("R7 disabled no irq", {31'b0, irq_sq}, 32'h0);
    wr(0, 12'h00C, 32'h1, 4'h1);
    chk("R7 no pending when disabled", {31'b0, irq_sq}, 32'h0);
    wr(0, 12'h000, 32'h7, 4'hF);
    wr(0, 12'h00C, 32'h0, 4'h1);
    chk("R7 disable masks pending", {31'b0, irq_sq}, 32'h0);
    wr(0, 12'h00C, 32'h1, 4'h1);
    chk("R7 re-enable shows pending", {31'b0, irq_sq}, 32'h1);

    // R9 unmapped and read-only offsets
    wr(1, 12'h200, 32'hFFFFFFFF, 4'hF);
    rd_chk("R9 unmapped read zero", 1, 12'h200);
    wr(0, 12'h014, 32'hFFFFFFFF, 4'hF);
    rd_chk("R9 own tail unchanged", 0, 12'h000);
    rd_chk("R9 peer tail unchanged", 0, 12'h100);

    // R8 soft reset from the consumer clears both queues
    wr(1, 12'h00C, 32'h8000_0000, 4'h8);
    irq_chk("R8");
    for (int i = 0; i < 10; i++) rd_chk("R8 cleared", 0, offs[i]);

    // R11 response held while ready is low
    wr(0, 12'h008, 32'hCAFEF00D, 4'hF, 0, 3);
    begin
      logic [31:0] e;
      e = m_rd_val(1, 12'h108);
      rd(1, 12'h108, v, 3);
      chk("R11 delayed read value", v, e);
    end

    // random mix
    for (int it = 0; it < 400; it++) begin
      int p = $urandom_range(1, 0);
      int k = $urandom_range(11, 0);
      logic [31:0] d = $urandom();
      logic [3:0] s = 4'($urandom());
      if ($urandom_range(19, 0) != 0) d[31] = 1'b0;
      if ($urandom_range(1, 0) == 1)
        wr(p, offs[k], d, s, $urandom_range(2, 0), $urandom_range(2, 0));
      else
        rd_chk("R2/R3 random read", p, offs[k]);
      irq_chk("R5/R6 random");
    end

    summary();
  end
endmodule